// File: doc/BRIEF.md
# Serial Flash Status Register Controller

This block is the slave-side logic of a serial flash device that serves the status register over a mode-0 SPI link: chip select (active low), serial clock, data in and data out. It decodes three one-byte instructions. Write-enable arms a latch. Read-status streams the status byte back. Write-status carries one data byte and, when accepted, starts a self-timed busy cycle. The length of that cycle in system clocks is a parameter. At the end of the cycle the new protection bits take effect and the enable latch drops.

All SPI inputs are sampled in the system clock domain, so the serial clock must run several times slower than `clk`. The device reset pin (active low) is honoured only between busy cycles. If it is asserted during a cycle, the cycle completes and commits first. A write-protect pin can lock the status register once the write-disable bit is set. The two protect bits and the write-disable bit are stored and presented on outputs. Mapping them to address ranges belongs to the surrounding flash logic.

Top module: `flash_status_ctrl`

## Requirements
- R1: Opcode 0x06 sets the enable latch (status bit 1) only when chip select rises after exactly 8 clocked bits. Any other bit count leaves it unchanged.
- R2: Opcode 0x05 returns the status byte MSB first. Each bit changes after a falling serial clock edge, starting with the falling edge that follows the eighth opcode bit. The byte repeats while chip select stays low. Layout: bit 7 write-disable, bits 6:4 zero, bits 3:2 protect bits, bit 1 enable latch, bit 0 busy.
- R3: `spi_miso_oe` is 0 whenever chip select is high, so data out is high-impedance. It is 1 while a read-status is streaming.
- R4: Opcode 0x01 followed by one data byte is ignored when the enable latch is clear.
- R5: A write-status frame executes only if chip select rises after exactly 16 clocked bits. At 15 or 17 bits nothing changes and no busy cycle starts.
- R6: An accepted write-status frame holds status bit 0 at 1 for WCYC_CLKS clocks. The register stays readable during this time and still shows the old protect bits. The new bits appear on `blk_prot` and `wr_disable` when the cycle ends.
- R7: The enable latch is cleared when the busy cycle ends.
- R8: A write changes only bits 7, 3 and 2. Bits 6:4 always read 0, and bits 1:0 never take values from the data byte.
- R9: While the write-disable bit is 1 and `wp_n` is low, a write-status frame is rejected. No cycle starts and the enable latch stays set.
- R10: Write-status and write-enable frames that end during a busy cycle are ignored.
- R11: `dev_rst_n` low outside a busy cycle clears the enable latch, aborts any frame in progress and keeps `spi_miso_oe` at 0. When it is low during a busy cycle, the cycle still completes and commits.
- R12: The synchronous reset `rst` clears every stored bit, ends the busy cycle and disables data out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_csn | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data in, MSB first |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for data out; 0 means high-impedance |
| dev_rst_n | input | 1 | Device reset pin, active low |
| wp_n | input | 1 | Write-protect pin, active low |
| blk_prot | output | 2 | Stored protect bits (status bits 3:2) |
| wr_disable | output | 1 | Stored write-disable bit (status bit 7) |

## Verification
A wrong enable latch or a wrong busy flag shows up on the very next read-status byte, because both bits are streamed live and are sampled at each falling edge. A wrong protect value shows up on `blk_prot` and `wr_disable` the clock after the busy cycle ends. The next status read then confirms it. A frame counter that slips by one bit shows up as a write that should have been refused but was accepted, or the reverse. The bench therefore exercises frames of 7, 9, 15 and 17 bits and compares the result with a bench-side model after every operation.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int OP_BITS = 8;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;

  // Status byte bit positions
  localparam int SB_BUSY = 0;
  localparam int SB_WEL  = 1;
  localparam int SB_PLO  = 2;
  localparam int SB_PHI  = 3;
  localparam int SB_WD   = 7;

  // Bits a status write may change
  localparam logic [7:0] WR_MASK = (8'(1) << SB_WD) | (8'(1) << SB_PHI) | (8'(1) << SB_PLO);

  function automatic logic [7:0] mk_status(input logic [7:0] prot, input logic wel, input logic busy);
    logic [7:0] s;
    s = prot & WR_MASK;
    s[SB_WEL]  = wel;
    s[SB_BUSY] = busy;
    return s;
  endfunction
endpackage

// File: rtl/fsc_spi_rx.sv
module fsc_spi_rx #(
  parameter int FRAME_BITS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             sck,
  input  logic             csn,
  input  logic             mosi,
  output logic             sck_fall,
  output logic             cs_high,
  output logic             cs_rise,
  output logic [$clog2(FRAME_BITS+2)-1:0] bit_cnt,
  output logic             op_done,
  output logic [7:0]       op_byte,
  output logic [7:0]       dat_byte
);
  import fsc_pkg::*;
  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_POISON = '1;
  localparam logic [CNT_W-1:0] OP_LAST  = CNT_W'(OP_BITS - 1);
  localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(2 * OP_BITS - 1);

  logic sck_s1, sck_s2, csn_s1, csn_s2, mosi_s1;
  logic sck_rise;
  logic [7:0] shreg;
  logic [7:0] nxt_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_s1 <= 1'b0; sck_s2 <= 1'b0;
      csn_s1 <= 1'b1; csn_s2 <= 1'b1;
      mosi_s1 <= 1'b0;
    end else begin
      sck_s1 <= sck;  sck_s2 <= sck_s1;
      csn_s1 <= csn;  csn_s2 <= csn_s1;
      mosi_s1 <= mosi;
    end
  end

  assign sck_rise = sck_s1 & ~sck_s2;
  assign sck_fall = ~sck_s1 & sck_s2;
  assign cs_high  = csn_s1;
  assign cs_rise  = csn_s1 & ~csn_s2;
  assign nxt_byte = {shreg[6:0], mosi_s1};

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt  <= '0;
      shreg    <= '0;
      op_done  <= 1'b0;
      op_byte  <= '0;
      dat_byte <= '0;
    end else begin
      op_done <= 1'b0;
      if (csn_s1) begin
        bit_cnt <= '0;
      end else if (hold) begin
        bit_cnt <= CNT_POISON;
      end else if (sck_rise && bit_cnt != CNT_POISON) begin
        bit_cnt <= bit_cnt + 1'b1;
        shreg   <= nxt_byte;
        if (bit_cnt == OP_LAST) begin
          op_byte <= nxt_byte;
          op_done <= 1'b1;
        end
        if (bit_cnt == DAT_LAST) dat_byte <= nxt_byte;
      end
    end
  end

  AST_OPCODE_AT_EIGHT: assert property (@(posedge clk) disable iff (rst)
    op_done |-> (bit_cnt == CNT_W'(OP_BITS))); // R1
endmodule

// File: rtl/fsc_wtimer.sv
module fsc_wtimer #(
  parameter int LEN = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic finish
);
  localparam int CW = $clog2(LEN + 1);
  localparam int RW = $clog2(LEN + 2);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) busy <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CW'(LEN);
    end
  end

  assign finish = busy && (cnt == CW'(1));

  // checker counter for cycle length
  logic [RW-1:0] run_q;
  always_ff @(posedge clk) begin
    if (rst)       run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_q == RW'(LEN))); // R6
endmodule

// File: rtl/fsc_tx.sv
module fsc_tx (
  input  logic       clk,
  input  logic       rst,
  input  logic       hold,
  input  logic       cs_high,
  input  logic       rd_start,
  input  logic       sck_fall,
  input  logic [7:0] status,
  output logic       miso,
  output logic       miso_oe
);
  logic       rd_active;
  logic [2:0] bcnt;
  logic [7:0] shreg;

  always_ff @(posedge clk) begin
    if (rst || cs_high || hold) begin
      rd_active <= 1'b0;
      bcnt      <= '0;
    end else if (rd_start) begin
      rd_active <= 1'b1;
      bcnt      <= '0;
    end else if (rd_active && sck_fall) begin
      bcnt <= bcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      miso    <= 1'b0;
      shreg   <= '0;
      miso_oe <= 1'b0;
    end else begin
      miso_oe <= rd_active && !cs_high && !hold;
      if (rd_active && sck_fall) begin
        if (bcnt == 3'd0) begin
          miso  <= status[7];
          shreg <= {status[6:0], 1'b0};
        end else begin
          miso  <= shreg[7];
          shreg <= {shreg[6:0], 1'b0};
        end
      end
    end
  end

  AST_OE_OFF_CS_HIGH: assert property (@(posedge clk) disable iff (rst)
    cs_high |=> !miso_oe); // R3
  AST_OE_OFF_HOLD: assert property (@(posedge clk) disable iff (rst)
    hold |=> !miso_oe); // R11
endmodule

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl #(
  parameter int WCYC_CLKS  = 1000,
  parameter int FRAME_BITS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       spi_sck,
  input  logic       spi_csn,
  input  logic       spi_mosi,
  output logic       spi_miso,
  output logic       spi_miso_oe,
  input  logic       dev_rst_n,
  input  logic       wp_n,
  output logic [1:0] blk_prot,
  output logic       wr_disable
);
  import fsc_pkg::*;
  localparam int CNT_W = $clog2(FRAME_BITS + 2);

  logic hold, wp_s1;
  logic sck_fall, cs_high, cs_rise, op_done;
  logic [CNT_W-1:0] bit_cnt;
  logic [7:0] op_byte, dat_byte;
  logic busy, finish;
  logic wel;
  logic [7:0] prot_q, pend_q;
  logic wr_go, wren_go, rd_start, wp_lock;
  logic [7:0] status;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold  <= 1'b0;
      wp_s1 <= 1'b1;
    end else begin
      hold  <= ~dev_rst_n;
      wp_s1 <= wp_n;
    end
  end

  fsc_spi_rx #(.FRAME_BITS(FRAME_BITS)) rx_i (
    .clk(clk), .rst(rst), .hold(hold),
    .sck(spi_sck), .csn(spi_csn), .mosi(spi_mosi),
    .sck_fall(sck_fall), .cs_high(cs_high), .cs_rise(cs_rise),
    .bit_cnt(bit_cnt), .op_done(op_done),
    .op_byte(op_byte), .dat_byte(dat_byte)
  );

  fsc_wtimer #(.LEN(WCYC_CLKS)) tmr_i (
    .clk(clk), .rst(rst), .start(wr_go), .busy(busy), .finish(finish)
  );

  assign wp_lock  = prot_q[SB_WD] && !wp_s1;
  assign wren_go  = cs_rise && !hold && !busy && (op_byte == OP_WREN)
                    && (bit_cnt == CNT_W'(OP_BITS));
  assign wr_go    = cs_rise && !hold && !busy && wel && !wp_lock
                    && (op_byte == OP_WRSR) && (bit_cnt == CNT_W'(FRAME_BITS));
  assign rd_start = op_done && !hold && (op_byte == OP_RDSR);
  assign status   = mk_status(prot_q, wel, busy);

  always_ff @(posedge clk) begin
    if (rst) begin
      wel    <= 1'b0;
      prot_q <= '0;
      pend_q <= '0;
    end else begin
      if (wr_go) pend_q <= dat_byte;
      if (finish) begin
        prot_q <= pend_q & WR_MASK;
        wel    <= 1'b0;
      end else if (hold && !busy) begin
        wel <= 1'b0;
      end else if (wren_go) begin
        wel <= 1'b1;
      end
    end
  end

  fsc_tx tx_i (
    .clk(clk), .rst(rst), .hold(hold), .cs_high(cs_high),
    .rd_start(rd_start), .sck_fall(sck_fall), .status(status),
    .miso(spi_miso), .miso_oe(spi_miso_oe)
  );

  assign blk_prot   = prot_q[SB_PHI:SB_PLO];
  assign wr_disable = prot_q[SB_WD];

  AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> wel); // R4
  AST_WEL_DROP_AT_END: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !wel); // R7
  AST_PROT_ONLY_AT_END: assert property (@(posedge clk) disable iff (rst)
    !$past(busy) |-> $stable(prot_q)); // R6
  AST_WP_NO_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !($past(prot_q[SB_WD]) && !$past(wp_s1))); // R9
  AST_NO_WEL_SET_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> !$rose(wel)); // R10
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (prot_q & ~WR_MASK) == 8'h00); // R8
endmodule

// File: tb/flash_status_ctrl_tb.sv
module flash_status_ctrl_tb_top;
  localparam int WCYC = 600;
  localparam int HP   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_sck = 1'b0, spi_csn = 1'b1, spi_mosi = 1'b0;
  logic dev_rst_n = 1'b1, wp_n = 1'b1;
  logic spi_miso, spi_miso_oe, wr_disable;
  logic [1:0] blk_prot;

  int nchk = 0, nfail = 0;
  logic last_oe;
  logic exp_wd = 1'b0, exp_wel = 1'b0;
  logic [1:0] exp_bp = 2'b00;

  always #2 clk = ~clk;

  flash_status_ctrl #(.WCYC_CLKS(WCYC)) dut_i (
    .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_csn(spi_csn),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .dev_rst_n(dev_rst_n), .wp_n(wp_n), .blk_prot(blk_prot), .wr_disable(wr_disable)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status(input logic busy);
    return {exp_wd, 3'b000, exp_bp, exp_wel, busy};
  endfunction

  // tx is left aligned: tx[31] goes first
  task automatic frame(input logic [31:0] tx, input int nbits, output logic [31:0] rx);
    rx = '0;
    @(negedge clk) spi_csn = 1'b0;
    repeat (HP) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = tx[31-i];
      repeat (HP) @(negedge clk);
      rx = {rx[30:0], spi_miso};
      if (i == nbits - 1) last_oe = spi_miso_oe;
      spi_sck = 1'b1;
      repeat (HP) @(negedge clk);
      spi_sck = 1'b0;
    end
    repeat (HP) @(negedge clk);
    spi_csn = 1'b1;
    repeat (2 * HP) @(negedge clk);
  endtask

  task automatic read_status(output logic [7:0] st);
    logic [31:0] rx;
    frame({8'h05, 24'h0}, 16, rx);
    st = rx[7:0];
  endtask

  task automatic send_wren(input int nbits);
    logic [31:0] rx;
    frame({8'h06, 24'h0}, nbits, rx);
  endtask

  task automatic send_wrsr(input logic [7:0] d, input int nbits);
    logic [31:0] rx;
    frame({8'h01, d, 16'h0}, nbits, rx);
  endtask

  task automatic wait_cycle();
    repeat (WCYC + 40) @(negedge clk);
  endtask

  initial begin
    logic [7:0] st;
    logic [31:0] rx;
    void'($urandom(32'd1234));
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R12 reset state
    chk("R12 blk_prot", blk_prot, 2'b00);
    chk("R12 wr_disable", wr_disable, 1'b0);
    chk("R12 oe", spi_miso_oe, 1'b0);
    read_status(st);
    chk("R12 status after reset", st, 8'h00);

    // R4 write without enable
    send_wrsr(8'h8C, 16);
    wait_cycle();
    read_status(st);
    chk("R4 ignored without wel", st, 8'h00);
    chk("R4 blk_prot", blk_prot, 2'b00);

    // R1 write enable
    send_wren(8);
    exp_wel = 1'b1;
    read_status(st);
    chk("R1 wel set", st, 8'h02);

    // R2 repeat and R3 oe
    frame({8'h05, 24'h0}, 24, rx);
    chk("R2 first byte", rx[15:8], 8'h02);
    chk("R2 repeated byte", rx[7:0], 8'h02);
    chk("R3 oe while reading", last_oe, 1'b1);
    chk("R3 oe with cs high", spi_miso_oe, 1'b0);

    // R5 wrong lengths
    send_wrsr(8'hFF, 15);
    read_status(st);
    chk("R5 15 bits", st, 8'h02);
    send_wrsr(8'hFF, 17);
    read_status(st);
    chk("R5 17 bits", st, 8'h02);

    // R6 busy cycle, R10 write during busy
    send_wrsr(8'hFF, 16);
    read_status(st);
    chk("R6 busy readable", st, 8'h03);
    chk("R6 prot unchanged during cycle", blk_prot, 2'b00);
    send_wrsr(8'h00, 16);
    wait_cycle();
    exp_wd = 1'b1; exp_bp = 2'b11; exp_wel = 1'b0;
    read_status(st);
    chk("R7 R8 R10 after cycle", st, 8'h8C);
    chk("R6 blk_prot", blk_prot, 2'b11);
    chk("R6 wr_disable", wr_disable, 1'b1);

    // R9 write protect
    wp_n = 1'b0;
    send_wren(8);
    exp_wel = 1'b1;
    send_wrsr(8'h00, 16);
    read_status(st);
    chk("R9 rejected", st, 8'h8E);
    wp_n = 1'b1;
    send_wrsr(8'h00, 16);
    wait_cycle();
    exp_wd = 1'b0; exp_bp = 2'b00; exp_wel = 1'b0;
    read_status(st);
    chk("R9 accepted with pin high", st, 8'h00);

    // R11 reset idle
    send_wren(8);
    @(negedge clk) dev_rst_n = 1'b0;
    frame({8'h05, 24'h0}, 16, rx);
    chk("R11 oe off in reset", last_oe, 1'b0);
    dev_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    read_status(st);
    chk("R11 wel cleared", st, 8'h00);

    // R11 reset mid-cycle
    send_wren(8);
    send_wrsr(8'h0C, 16);
    dev_rst_n = 1'b0;
    repeat (20) @(negedge clk);
    dev_rst_n = 1'b1;
    wait_cycle();
    exp_bp = 2'b11;
    chk("R11 cycle completes", blk_prot, 2'b11);
    read_status(st);
    chk("R11 status after cycle", st, 8'h0C);

    // R1 bad count
    send_wren(9);
    read_status(st);
    chk("R1 nine bits ignored", st, 8'h0C);

    // random mix
    for (int it = 0; it < 40; it++) begin
      int op;
      int nb;
      logic [7:0] d;
      op = int'($urandom % 4);
      wp_n = 1'($urandom);
      repeat (4) @(negedge clk);
      case (op)
        0: begin send_wren(8); exp_wel = 1'b1; end
        1: begin
          d = 8'($urandom);
          nb = (($urandom % 4) == 0) ? 15 + 2 * int'($urandom % 2) : 16;
          send_wrsr(d, nb);
          if (exp_wel && nb == 16 && !(exp_wd && !wp_n)) begin
            wait_cycle();
            exp_wd = d[7]; exp_bp = d[3:2]; exp_wel = 1'b0;
          end
        end
        2: ;
        default: send_wren((($urandom % 2) == 0) ? 7 : 9);
      endcase
      read_status(st);
      chk("R1 R5 R8 R9 random", st, exp_status(1'b0));
      chk("R6 random blk_prot", blk_prot, exp_bp);
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule